// File: doc/BRIEF.md
# Dual Byte FIFO With Partitioned Extension Pool

This block holds two byte queues between a host and a line-side data path that share one clock. The transmit queue takes bytes from the host and hands them to the line side. The receive queue takes bytes from the line side and hands them to the host. Each queue has a fixed base depth. A common pool of extra entries is split between the two queues by a host split register. Writing that register moves the boundary and empties both queues.

The host can switch the transmit queue off. While it is off, a host byte goes to a single holding register, and the line side takes it from there. The block reports four status flags: transmit not full, transmit half-full, receive empty and receive half-full. Whenever a status flag changes, the change is latched as an event. The masked events are ORed into one interrupt request. Writes to a full queue and reads from an empty queue set sticky error flags. The host clears events and errors with write-one-to-clear pulses.

Top module: `dual_fifo_ext`

## Requirements
- R1: The transmit depth is BASE_DEPTH plus the split value, and the receive depth is BASE_DEPTH plus EXT_TOTAL minus the split value. A split value above EXT_TOTAL is clamped to EXT_TOTAL. The split resets to 0.
- R2: Each queue returns bytes in write order. Read data is registered: it appears on the data output after the clock edge that accepts the read and holds its value until the next accepted read.
- R3: A write to a full queue is dropped. It sets the sticky error bit 0 (transmit overrun) or bit 2 (receive overrun).
- R4: A read from an empty queue leaves the data output unchanged. It sets the sticky error bit 1 (transmit underrun) or bit 3 (receive underrun).
- R5: Status bit 0 is transmit not full, and bit 1 is transmit half-full. Bit 2 is receive empty, and bit 3 is receive half-full. A queue is half-full when its fill is at least its depth divided by two, rounded up.
- R6: A split register write flushes both queues on that edge. Any push or pop in the same cycle is discarded.
- R7: While tx_en is low, a host transmit write loads the holding register, overwriting any byte already there, and sets it valid. line_tx_avail shows the valid bit. A line read of a valid hold byte delivers it and clears the valid bit. A line read with the hold empty sets bit 1.
- R8: When a status bit changes, the matching event bit is set on the following edge. irq_clr clears event bits. A set in the same cycle wins over the clear.
- R9: irq is high exactly when some event bit and its irq_mask bit are both 1.
- R10: err_clr clears error bits. A new error in the same cycle wins over the clear.
- R11: After reset, both queues are empty, the data outputs are 0, and the status is 4'b0101. No event or error is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_split_we | input | 1 | Load the split register and flush both queues |
| cfg_split_data | input | SW | Number of extension entries given to transmit |
| tx_en | input | 1 | Transmit queue enable |
| host_tx_we | input | 1 | Host transmit write |
| host_tx_data | input | DW | Host transmit byte |
| line_tx_re | input | 1 | Line-side transmit read |
| line_tx_data | output | DW | Registered transmit byte to the line side |
| line_tx_avail | output | 1 | A transmit byte is available to read |
| line_rx_we | input | 1 | Line-side receive write |
| line_rx_data | input | DW | Receive byte from the line side |
| host_rx_re | input | 1 | Host receive read |
| host_rx_data | output | DW | Registered receive byte to the host |
| status | output | 4 | Status flags, positions as in R5 |
| err_flags | output | 4 | Sticky error flags, positions as in R3 and R4 |
| err_clr | input | 4 | Write-one-to-clear for err_flags |
| irq_mask | input | 4 | Interrupt mask, one bit per event |
| irq_clr | input | 4 | Write-one-to-clear for irq_events |
| irq_events | output | 4 | Latched status-change events |
| irq | output | 1 | Interrupt request |

## Verification
The bench builds the block with BASE_DEPTH of 4 and EXT_TOTAL of 10, so SW is 4 bits wide. A queue can then be filled to the limit in a few cycles at every split setting. Odd depths such as 5 bring the rounded-up half-full threshold within reach. A split value of 15 can be written, which exercises the clamp. At these sizes, random phases of writes and reads keep crossing full, empty and half-full, which drives the events and errors through many set and clear collisions.

// File: rtl/dfx_pkg.sv
package dfx_pkg;

    typedef struct packed {
        logic rx_half;
        logic rx_empty;
        logic tx_half;
        logic tx_nfull;
    } stat_t;

    typedef struct packed {
        logic rx_under;
        logic rx_over;
        logic tx_under;
        logic tx_over;
    } err_t;

    localparam stat_t STAT_AT_RESET = '{rx_half: 1'b0, rx_empty: 1'b1,
                                        tx_half: 1'b0, tx_nfull: 1'b1};

    localparam int SIDE_TX = 0;
    localparam int SIDE_RX = 1;

    function automatic int half_mark(input int depth);
        return (depth + 1) / 2;
    endfunction

endpackage

// File: rtl/dfx_fifo_ctl.sv
module dfx_fifo_ctl #(
    parameter int CW = 9
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          flush,
    input  logic [CW-1:0] depth,
    input  logic          push,
    input  logic          pop,
    output logic [CW-1:0] wr_idx,
    output logic [CW-1:0] rd_idx,
    output logic [CW-1:0] count,
    output logic          push_ok,
    output logic          pop_ok
);
    logic [CW-1:0] last_idx;

    assign last_idx = depth - CW'(1);
    assign push_ok  = push && !flush && (count < depth);
    assign pop_ok   = pop && !flush && (count != '0);

    always_ff @(posedge clk) begin
        if (rst || flush) begin
            wr_idx <= '0;
            rd_idx <= '0;
            count  <= '0;
        end else begin
            if (push_ok) wr_idx <= (wr_idx == last_idx) ? '0 : wr_idx + CW'(1);
            if (pop_ok)  rd_idx <= (rd_idx == last_idx) ? '0 : rd_idx + CW'(1);
            case ({push_ok, pop_ok})
                2'b10:   count <= count + CW'(1);
                2'b01:   count <= count - CW'(1);
                default: count <= count;
            endcase
        end
    end
endmodule

// File: rtl/dfx_evt_unit.sv
module dfx_evt_unit
    import dfx_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  stat_t       stat_now,
    input  err_t        err_set,
    input  logic [3:0]  err_clr,
    input  logic [3:0]  irq_mask,
    input  logic [3:0]  irq_clr,
    output logic [3:0]  events,
    output err_t        errs,
    output logic        irq
);
    stat_t stat_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            stat_q <= STAT_AT_RESET;
            events <= '0;
            errs   <= '0;
        end else begin
            stat_q <= stat_now;
            events <= (events & ~irq_clr) | (stat_now ^ stat_q);
            errs   <= err_t'((errs & ~err_clr) | err_set);
        end
    end

    assign irq = |(events & irq_mask);
endmodule

// File: rtl/dual_fifo_ext.sv
module dual_fifo_ext
    import dfx_pkg::*;
#(
    parameter int DW         = 8,
    parameter int BASE_DEPTH = 16,
    parameter int EXT_TOTAL  = 255,
    localparam int SW        = $clog2(EXT_TOTAL + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          cfg_split_we,
    input  logic [SW-1:0] cfg_split_data,
    input  logic          tx_en,
    input  logic          host_tx_we,
    input  logic [DW-1:0] host_tx_data,
    input  logic          line_tx_re,
    output logic [DW-1:0] line_tx_data,
    output logic          line_tx_avail,
    input  logic          line_rx_we,
    input  logic [DW-1:0] line_rx_data,
    input  logic          host_rx_re,
    output logic [DW-1:0] host_rx_data,
    output logic [3:0]    status,
    output logic [3:0]    err_flags,
    input  logic [3:0]    err_clr,
    input  logic [3:0]    irq_mask,
    input  logic [3:0]    irq_clr,
    output logic [3:0]    irq_events,
    output logic          irq
);
    localparam int TOTAL = 2 * BASE_DEPTH + EXT_TOTAL;
    localparam int AW    = $clog2(TOTAL);
    localparam int CW    = $clog2(BASE_DEPTH + EXT_TOTAL + 1);

    logic [SW-1:0] split_q;
    logic [CW-1:0] depth_a [2];
    logic [CW-1:0] wr_a    [2];
    logic [CW-1:0] rd_a    [2];
    logic [CW-1:0] cnt_a   [2];
    logic [CW-1:0] half_a  [2];
    logic [1:0]    push_a, pop_a, push_ok_a, pop_ok_a;
    logic [CW-1:0] tx_depth, rx_depth, tx_count, rx_count;
    logic [AW-1:0] rx_base;
    logic [DW-1:0] mem [TOTAL];
    logic [DW-1:0] hold_q;
    logic          hold_v;
    logic [DW-1:0] ltx_q, hrx_q;
    stat_t         stat_now;
    err_t          err_set, errs;

    // split register, clamped to the pool size
    always_ff @(posedge clk) begin
        if (rst)
            split_q <= '0;
        else if (cfg_split_we)
            split_q <= (cfg_split_data > SW'(EXT_TOTAL)) ? SW'(EXT_TOTAL) : cfg_split_data;
    end

    always_comb begin
        depth_a[SIDE_TX] = CW'(BASE_DEPTH) + CW'(split_q);
        depth_a[SIDE_RX] = CW'(BASE_DEPTH + EXT_TOTAL) - CW'(split_q);
        push_a[SIDE_TX]  = host_tx_we && tx_en;
        pop_a[SIDE_TX]   = line_tx_re && tx_en;
        push_a[SIDE_RX]  = line_rx_we;
        pop_a[SIDE_RX]   = host_rx_re;
    end

    for (genvar g = 0; g < 2; g++) begin : g_side
        dfx_fifo_ctl #(.CW(CW)) ctl_i (
            .clk    (clk),
            .rst    (rst),
            .flush  (cfg_split_we),
            .depth  (depth_a[g]),
            .push   (push_a[g]),
            .pop    (pop_a[g]),
            .wr_idx (wr_a[g]),
            .rd_idx (rd_a[g]),
            .count  (cnt_a[g]),
            .push_ok(push_ok_a[g]),
            .pop_ok (pop_ok_a[g])
        );
        assign half_a[g] = CW'(half_mark(int'(depth_a[g])));
    end

    assign tx_depth = depth_a[SIDE_TX];
    assign rx_depth = depth_a[SIDE_RX];
    assign tx_count = cnt_a[SIDE_TX];
    assign rx_count = cnt_a[SIDE_RX];
    assign rx_base  = AW'(tx_depth);

    // shared storage: transmit region below the boundary, receive above
    always_ff @(posedge clk) begin
        if (push_ok_a[SIDE_TX]) mem[AW'(wr_a[SIDE_TX])] <= host_tx_data;
        if (push_ok_a[SIDE_RX]) mem[rx_base + AW'(wr_a[SIDE_RX])] <= line_rx_data;
    end

    // holding register used while the transmit queue is disabled
    always_ff @(posedge clk) begin
        if (rst) begin
            hold_q <= '0;
            hold_v <= 1'b0;
        end else if (!tx_en) begin
            if (host_tx_we) begin
                hold_q <= host_tx_data;
                hold_v <= 1'b1;
            end else if (line_tx_re) begin
                hold_v <= 1'b0;
            end
        end
    end

    // registered read ports
    always_ff @(posedge clk) begin
        if (rst) begin
            ltx_q <= '0;
            hrx_q <= '0;
        end else begin
            if (pop_ok_a[SIDE_TX])
                ltx_q <= mem[AW'(rd_a[SIDE_TX])];
            else if (!tx_en && line_tx_re && hold_v)
                ltx_q <= hold_q;
            if (pop_ok_a[SIDE_RX])
                hrx_q <= mem[rx_base + AW'(rd_a[SIDE_RX])];
        end
    end

    always_comb begin
        stat_now.tx_nfull = tx_count < tx_depth;
        stat_now.tx_half  = tx_count >= half_a[SIDE_TX];
        stat_now.rx_empty = rx_count == '0;
        stat_now.rx_half  = rx_count >= half_a[SIDE_RX];
        err_set.tx_over   = push_a[SIDE_TX] && !cfg_split_we && !stat_now.tx_nfull;
        err_set.tx_under  = line_tx_re && (tx_en ? (!cfg_split_we && tx_count == '0) : !hold_v);
        err_set.rx_over   = line_rx_we && !cfg_split_we && (rx_count >= rx_depth);
        err_set.rx_under  = host_rx_re && !cfg_split_we && stat_now.rx_empty;
    end

    dfx_evt_unit evt_i (
        .clk     (clk),
        .rst     (rst),
        .stat_now(stat_now),
        .err_set (err_set),
        .err_clr (err_clr),
        .irq_mask(irq_mask),
        .irq_clr (irq_clr),
        .events  (irq_events),
        .errs    (errs),
        .irq     (irq)
    );

    assign line_tx_data  = ltx_q;
    assign host_rx_data  = hrx_q;
    assign line_tx_avail = tx_en ? (tx_count != '0) : hold_v;
    assign status        = stat_now;
    assign err_flags     = errs;
endmodule

// File: rtl/dual_fifo_ext_chk.sv
module dual_fifo_ext_chk #(
    parameter int CW = 9,
    parameter int DW = 8
) (
    input logic          clk,
    input logic          rst,
    input logic          cfg_split_we,
    input logic          tx_en,
    input logic          host_tx_we,
    input logic          host_rx_re,
    input logic [DW-1:0] host_rx_data,
    input logic          line_tx_avail,
    input logic [3:0]    status,
    input logic [3:0]    err_flags,
    input logic [3:0]    irq_mask,
    input logic [3:0]    irq_events,
    input logic          irq,
    input logic [CW-1:0] tx_count,
    input logic [CW-1:0] rx_count,
    input logic [CW-1:0] tx_depth,
    input logic [CW-1:0] rx_depth
);
    assert_no_overflow_R3: assert property (@(posedge clk) disable iff (rst)
        (tx_count <= tx_depth) && (rx_count <= rx_depth));

    assert_split_flush_R6: assert property (@(posedge clk) disable iff (rst)
        cfg_split_we |=> (tx_count == '0) && (rx_count == '0));

    assert_rx_underrun_R4: assert property (@(posedge clk) disable iff (rst)
        (host_rx_re && status[2] && !cfg_split_we) |=> (err_flags[3] && $stable(host_rx_data)));

    assert_half_rx_R5: assert property (@(posedge clk) disable iff (rst)
        status[3] |-> !status[2]);

    assert_half_tx_R5: assert property (@(posedge clk) disable iff (rst)
        !status[0] |-> status[1]);

    assert_hold_valid_R7: assert property (@(posedge clk) disable iff (rst)
        (!tx_en && host_tx_we) |=> (tx_en || line_tx_avail));

    assert_event_latch_R8: assert property (@(posedge clk) disable iff (rst)
        !$stable(status) |=> ((irq_events & $past(status ^ $past(status))) == $past(status ^ $past(status))));

    assert_irq_cause_R9: assert property (@(posedge clk) disable iff (rst)
        $rose(irq) |-> ((irq_events & irq_mask) != 4'b0));
endmodule

bind dual_fifo_ext dual_fifo_ext_chk #(.CW(CW), .DW(DW)) chk_i (
    .clk          (clk),
    .rst          (rst),
    .cfg_split_we (cfg_split_we),
    .tx_en        (tx_en),
    .host_tx_we   (host_tx_we),
    .host_rx_re   (host_rx_re),
    .host_rx_data (host_rx_data),
    .line_tx_avail(line_tx_avail),
    .status       (status),
    .err_flags    (err_flags),
    .irq_mask     (irq_mask),
    .irq_events   (irq_events),
    .irq          (irq),
    .tx_count     (tx_count),
    .rx_count     (rx_count),
    .tx_depth     (tx_depth),
    .rx_depth     (rx_depth)
);

// File: tb/dual_fifo_ext_tb_top.sv
module dual_fifo_ext_tb_top;
    localparam int BASE = 4;
    localparam int EXT  = 10;
    localparam int SW   = $clog2(EXT + 1);

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          cfg_split_we = 1'b0;
    logic [SW-1:0] cfg_split_data = '0;
    logic          tx_en = 1'b1;
    logic          host_tx_we = 1'b0;
    logic [7:0]    host_tx_data = '0;
    logic          line_tx_re = 1'b0;
    logic [7:0]    line_tx_data;
    logic          line_tx_avail;
    logic          line_rx_we = 1'b0;
    logic [7:0]    line_rx_data = '0;
    logic          host_rx_re = 1'b0;
    logic [7:0]    host_rx_data;
    logic [3:0]    status, err_flags, irq_events;
    logic [3:0]    err_clr = '0;
    logic [3:0]    irq_mask = '0;
    logic [3:0]    irq_clr = '0;
    logic          irq;

    always #2 clk = ~clk;

    dual_fifo_ext #(.DW(8), .BASE_DEPTH(BASE), .EXT_TOTAL(EXT)) dut_i (
        .clk(clk), .rst(rst), .cfg_split_we(cfg_split_we), .cfg_split_data(cfg_split_data),
        .tx_en(tx_en), .host_tx_we(host_tx_we), .host_tx_data(host_tx_data),
        .line_tx_re(line_tx_re), .line_tx_data(line_tx_data), .line_tx_avail(line_tx_avail),
        .line_rx_we(line_rx_we), .line_rx_data(line_rx_data), .host_rx_re(host_rx_re),
        .host_rx_data(host_rx_data), .status(status), .err_flags(err_flags),
        .err_clr(err_clr), .irq_mask(irq_mask), .irq_clr(irq_clr),
        .irq_events(irq_events), .irq(irq)
    );

    int checks = 0;
    int errors = 0;
    bit done = 0;

    // reference model state
    int         m_split;
    logic [7:0] txq[$];
    logic [7:0] rxq[$];
    logic [3:0] m_ev, m_err, m_sprev;
    logic [7:0] m_ltx, m_hrx, m_hold;
    bit         m_hv;

    function automatic int tx_depth_m();
        return BASE + m_split;
    endfunction
    function automatic int rx_depth_m();
        return BASE + EXT - m_split;
    endfunction
    function automatic int half_m(input int d);
        return (d + 1) / 2;
    endfunction
    function automatic logic [3:0] stat_m();
        logic [3:0] s;
        s[0] = txq.size() < tx_depth_m();
        s[1] = txq.size() >= half_m(tx_depth_m());
        s[2] = rxq.size() == 0;
        s[3] = rxq.size() >= half_m(rx_depth_m());
        return s;
    endfunction

    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s got %0h exp %0h", tag, got, exp);
        end
    endtask

    task automatic compare_all();
        chk("R2 line_tx_data", 32'(line_tx_data), 32'(m_ltx));
        chk("R2 host_rx_data", 32'(host_rx_data), 32'(m_hrx));
        chk("R7 line_tx_avail", 32'(line_tx_avail), 32'(tx_en ? (txq.size() != 0) : m_hv));
        chk("R5 R1 status", 32'(status), 32'(stat_m()));
        chk("R3 R4 R10 err_flags", 32'(err_flags), 32'(m_err));
        chk("R8 irq_events", 32'(irq_events), 32'(m_ev));
        chk("R9 irq", 32'(irq), 32'(|(m_ev & irq_mask)));
    endtask

    task automatic model_edge();
        logic [3:0] s, nerr;
        bit tfull, tempt, rfull, rempt;
        s = stat_m();
        nerr = '0;
        if (cfg_split_we) begin
            txq.delete();
            rxq.delete();
        end else begin
            if (tx_en) begin
                tfull = txq.size() >= tx_depth_m();
                tempt = txq.size() == 0;
                if (line_tx_re) begin
                    if (tempt) nerr[1] = 1'b1;
                    else m_ltx = txq.pop_front();
                end
                if (host_tx_we) begin
                    if (tfull) nerr[0] = 1'b1;
                    else txq.push_back(host_tx_data);
                end
            end
            rfull = rxq.size() >= rx_depth_m();
            rempt = rxq.size() == 0;
            if (host_rx_re) begin
                if (rempt) nerr[3] = 1'b1;
                else m_hrx = rxq.pop_front();
            end
            if (line_rx_we) begin
                if (rfull) nerr[2] = 1'b1;
                else rxq.push_back(line_rx_data);
            end
        end
        if (!tx_en) begin
            if (line_tx_re) begin
                if (m_hv) begin
                    m_ltx = m_hold;
                    m_hv = 0;
                end else nerr[1] = 1'b1;
            end
            if (host_tx_we) begin
                m_hold = host_tx_data;
                m_hv = 1;
            end
        end
        m_err = (m_err & ~err_clr) | nerr;
        m_ev = (m_ev & ~irq_clr) | (s ^ m_sprev);
        m_sprev = s;
        if (cfg_split_we) m_split = (int'(cfg_split_data) > EXT) ? EXT : int'(cfg_split_data);
    endtask

    task automatic step();
        @(posedge clk);
        model_edge();
        @(negedge clk);
        compare_all();
        cfg_split_we = 0; host_tx_we = 0; line_tx_re = 0;
        line_rx_we = 0; host_rx_re = 0; err_clr = '0; irq_clr = '0;
    endtask

    task automatic set_split(input int v);
        cfg_split_we = 1;
        cfg_split_data = SW'(v);
        step();
    endtask

    task automatic push_tx(input int n);
        for (int i = 0; i < n; i++) begin
            host_tx_we = 1;
            host_tx_data = 8'($urandom);
            step();
        end
    endtask

    task automatic push_rx(input int n);
        for (int i = 0; i < n; i++) begin
            line_rx_we = 1;
            line_rx_data = 8'($urandom);
            step();
        end
    endtask

    task automatic pop_tx(input int n);
        for (int i = 0; i < n; i++) begin
            line_tx_re = 1;
            step();
        end
    endtask

    task automatic pop_rx(input int n);
        for (int i = 0; i < n; i++) begin
            host_rx_re = 1;
            step();
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd4242));
        m_split = 0; m_ev = '0; m_err = '0; m_sprev = 4'b0101;
        m_ltx = '0; m_hrx = '0; m_hold = '0; m_hv = 0;
        repeat (4) @(posedge clk);
        @(negedge clk);
        rst = 0;
        // R11: reset state
        compare_all();
        step();

        // R1 R3: default split gives transmit depth 4, fifth write overruns
        push_tx(5);
        // R1: receive depth 14 at split 0
        push_rx(15);
        // R2 R4: drain receive, one extra read underruns with data held
        pop_rx(15);
        pop_tx(5);
        // R10: clear errors, R8 R9: mask and clear events
        irq_mask = 4'b1111;
        step();
        err_clr = 4'hF;
        irq_clr = 4'hF;
        step();
        step();

        // R5: split 1 gives transmit depth 5, half at 3
        set_split(1);
        push_tx(2);
        push_tx(1);
        push_tx(3);
        // R6: split write flushes both queues
        push_rx(3);
        set_split(1);
        step();
        // R1: value above pool size is clamped, transmit depth 14
        set_split(15);
        push_tx(15);
        pop_tx(15);

        // R7: disabled transmit uses the holding register
        tx_en = 0;
        step();
        line_tx_re = 1;
        step();
        push_tx(2);
        pop_tx(1);
        host_tx_we = 1; host_tx_data = 8'hA5; line_tx_re = 1;
        step();
        pop_tx(2);
        tx_en = 1;
        step();

        // R8 R10: set and clear in the same cycle, set wins
        push_rx(1);
        host_rx_re = 1; host_rx_re = 1; irq_clr = 4'hF;
        step();
        host_rx_re = 1; err_clr = 4'h8;
        step();

        // random phases over all features
        for (int ph = 0; ph < 24; ph++) begin
            int fillp;
            fillp = (ph % 2 == 0) ? 80 : 20;
            if (ph % 3 == 0) set_split(int'($urandom_range(0, 15)));
            tx_en = ($urandom_range(0, 9) != 0);
            for (int c = 0; c < 120; c++) begin
                host_tx_we   = ($urandom_range(0, 99) < fillp);
                host_tx_data = 8'($urandom);
                line_tx_re   = ($urandom_range(0, 99) < 100 - fillp);
                line_rx_we   = ($urandom_range(0, 99) < fillp);
                line_rx_data = 8'($urandom);
                host_rx_re   = ($urandom_range(0, 99) < 100 - fillp);
                if ($urandom_range(0, 15) == 0) err_clr = 4'($urandom);
                if ($urandom_range(0, 15) == 0) irq_clr = 4'($urandom);
                if ($urandom_range(0, 31) == 0) irq_mask = 4'($urandom);
                if ($urandom_range(0, 199) == 0) begin
                    cfg_split_we = 1;
                    cfg_split_data = SW'($urandom);
                end
                step();
            end
        end

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule